// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns a 32-bit linear address into a physical address. It checks an eight-entry translation cache first. On a miss it walks a two-level page table kept in external memory. A linear address splits into three fields: bits 31:22 index the top-level directory, bits 21:12 index a second-level table, and bits 11:0 are the byte offset within a 4 KB page. Each table entry is a 32-bit word. Bits 31:12 of an entry hold a frame base, and bit 0 marks the entry as present.

A requester offers one address at a time on a valid/ready request channel, together with a user-mode flag. The request transfers on a clock edge where `req_valid` and `req_ready` are both high. The unit holds `req_ready` low from that edge until its answer has been taken. The answer appears on a valid/ready response channel. While `rsp_ready` is low, the unit keeps `rsp_valid`, `rsp_paddr` and `rsp_fault` unchanged.

Table words are fetched through a read port. A read request transfers when `mem_req_valid` and `mem_req_ready` are both high. The memory answers later with a one-cycle `mem_rsp_valid` pulse. No second read is issued before that pulse arrives.

Software loads the directory base through `base_wr`/`base_data`, and can empty the cache with `flush`.

Top module: `xlt_unit`

## Requirements
- R1: The first read of a walk fetches the directory entry at address `base + 4*va[31:22]`, where `base` is the value last loaded through `base_wr`.
- R2: The second read of a walk fetches the table entry at address `{dirent[31:12], 12'h000} + 4*va[21:12]`.
- R3: A successful translation returns `rsp_paddr = {pte[31:12], va[11:0]}` with `rsp_fault = 2'b00`.
- R4: If bit 0 of the directory entry is 0, the walk ends after that single read. The response carries `rsp_fault = 2'b01` and `rsp_paddr = 0`.
- R5: If bit 0 of the table entry is 0, the response carries `rsp_fault = 2'b01` and `rsp_paddr = 0`, and no cache entry is filled. Repeating the request walks again with two reads.
- R6: A user-mode request (`req_user = 1`) to any address at or above 0xC0000000 returns `rsp_fault = 2'b10` with `rsp_paddr = 0` and issues no memory read, even if that page is cached. Kernel-mode requests may translate any address, and user-mode requests up to 0xBFFFFFFF translate normally.
- R7: A request that hits the cache issues no memory read. Its `rsp_valid` is high in the cycle right after the request is accepted.
- R8: The cache holds 8 pages, replaced in round-robin order. After 8 fills, a 9th fill evicts the oldest entry and keeps the other 7.
- R9: A one-cycle `flush` pulse empties the cache, so the next request to any page walks the tables again.
- R10: A write to the base register empties the cache, and later walks use the new base.
- R11: `req_ready` stays low from acceptance until the response is taken. While `rsp_ready` is low, the response stays valid and unchanged.
- R12: After reset, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties the translation cache |
| base_wr | input | 1 | Loads the directory base register and empties the cache |
| base_data | input | 32 | Physical address of the top-level directory |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 ok, 01 entry not present, 10 privilege |
| mem_req_valid | output | 1 | Table read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the table word |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | 32 | Table entry word |

## Verification
The bench aims at the two places where the present bit can be clear.

- **Directory level:** a design that ignored the bit there would issue a second read from a garbage table.
- **Table level:** a design that filled the cache anyway would answer the repeated request as a hit, with zero reads.

The bench tests the privilege boundary on both sides of 0xC0000000, and also on a page the kernel has already cached. A check that came after the cache lookup would wrongly return a translation there.

It runs nine distinct pages through the cache to expose replacement that is not round-robin.

It flushes the cache and rewrites the base to catch stale hits.

It holds `rsp_ready` low to catch a response that moves or drops while stalled.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PRIV   = 2'd2
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_RESP
  } wst_e;
endpackage

// File: rtl/xlt_tcache.sv
module xlt_tcache #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) lk_frame = lk_frame | frame_q[i];
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (clear) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_en) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && !clear && ptr_q == PTR_W'(i)) begin
        tag_q[i]   <= fill_tag;
        frame_q[i] <= fill_frame;
      end
    end
  end

  // fills only follow misses, so a tag never sits in two entries
  p_onehot_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !lk_hit);
endmodule

// File: rtl/xlt_walk.sv
module xlt_walk
  import xlt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10,
  parameter logic [ADDR_W-1:0] KSPACE_BASE = 32'hC000_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inval,
  input  logic [ADDR_W-1:0]           base_q,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_vaddr,
  input  logic                        req_user,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [ADDR_W-1:0]           rsp_paddr,
  output flt_e                        rsp_fault,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [ADDR_W-1:0]           mem_rsp_data,
  input  logic                        hit,
  input  logic [ADDR_W-PAGE_BITS-1:0] hit_frame,
  output logic                        fill_en,
  output logic [ADDR_W-PAGE_BITS-1:0] fill_tag,
  output logic [ADDR_W-PAGE_BITS-1:0] fill_frame
);
  localparam int FRAME_W   = ADDR_W - PAGE_BITS;
  localparam int ENT_SHIFT = 2;

  wst_e               st_q;
  logic [ADDR_W-1:0]  va_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [ADDR_W-1:0]  paddr_q;
  flt_e               flt_q;
  logic               stale_q;
  logic               priv_viol;
  logic               accept;
  logic [IDX_W-1:0]   dir_idx, tbl_idx;
  logic               unused_bits;

  assign unused_bits = ^mem_rsp_data[PAGE_BITS-1:1];
  assign dir_idx     = va_q[ADDR_W-1 -: IDX_W];
  assign tbl_idx     = va_q[PAGE_BITS +: IDX_W];
  assign priv_viol   = req_user && (req_vaddr >= KSPACE_BASE);
  assign req_ready   = (st_q == ST_IDLE) && !inval;
  assign accept      = req_valid && req_ready;

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = flt_q;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = '0;
    if (st_q == ST_DIR_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = base_q + (ADDR_W'(dir_idx) << ENT_SHIFT);
    end else if (st_q == ST_TBL_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = {tbl_q, {PAGE_BITS{1'b0}}} + (ADDR_W'(tbl_idx) << ENT_SHIFT);
    end
  end

  assign fill_en    = (st_q == ST_TBL_WAIT) && mem_rsp_valid && mem_rsp_data[0]
                      && !stale_q && !inval;
  assign fill_tag   = va_q[ADDR_W-1:PAGE_BITS];
  assign fill_frame = mem_rsp_data[ADDR_W-1:PAGE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
      flt_q   <= FLT_NONE;
      stale_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          va_q    <= req_vaddr;
          stale_q <= 1'b0;
          if (priv_viol) begin
            paddr_q <= '0;
            flt_q   <= FLT_PRIV;
            st_q    <= ST_RESP;
          end else if (hit) begin
            paddr_q <= {hit_frame, req_vaddr[PAGE_BITS-1:0]};
            flt_q   <= FLT_NONE;
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            paddr_q <= '0;
            flt_q   <= FLT_ABSENT;
            st_q    <= ST_RESP;
          end else begin
            tbl_q <= mem_rsp_data[ADDR_W-1:PAGE_BITS];
            st_q  <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_req_ready) st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            paddr_q <= '0;
            flt_q   <= FLT_ABSENT;
          end else begin
            paddr_q <= {mem_rsp_data[ADDR_W-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
            flt_q   <= FLT_NONE;
          end
          st_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      // an invalidate during a walk keeps its result out of the cache
      if (inval && st_q != ST_IDLE) stale_q <= 1'b1;
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);
  p_priv_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_user && req_vaddr >= KSPACE_BASE)
      |=> (rsp_valid && rsp_fault == FLT_PRIV));
  p_hit_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit && !priv_viol) |=> (rsp_valid && rsp_fault == FLT_NONE));
endmodule

// File: rtl/xlt_unit.sv
module xlt_unit
  import xlt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10,
  parameter int ENTRIES   = 8,
  parameter logic [ADDR_W-1:0] KSPACE_BASE = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int FRAME_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0]  base_q;
  logic               inval;
  logic               hit;
  logic [FRAME_W-1:0] hit_frame;
  logic               fill_en;
  logic [FRAME_W-1:0] fill_tag, fill_frame;
  flt_e               flt;

  assign inval     = flush | base_wr;
  assign rsp_fault = flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= base_data;
  end

  xlt_tcache #(
    .ENTRIES (ENTRIES),
    .TAG_W   (FRAME_W),
    .FRAME_W (FRAME_W)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (inval),
    .lk_tag     (req_vaddr[ADDR_W-1:PAGE_BITS]),
    .lk_hit     (hit),
    .lk_frame   (hit_frame),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .fill_frame (fill_frame)
  );

  xlt_walk #(
    .ADDR_W      (ADDR_W),
    .PAGE_BITS   (PAGE_BITS),
    .IDX_W       (IDX_W),
    .KSPACE_BASE (KSPACE_BASE)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inval         (inval),
    .base_q        (base_q),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_user      (req_user),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (flt),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .hit           (hit),
    .hit_frame     (hit_frame),
    .fill_en       (fill_en),
    .fill_tag      (fill_tag),
    .fill_frame    (fill_frame)
  );

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && !mem_req_valid));
endmodule

// File: tb/xlt_unit_bench.sv
`timescale 1ns/1ps
module xlt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic        req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, bad = 0, reads = 0, rsp_cnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [$];

  typedef struct { logic [31:0] pa; logic [1:0] flt; string req; } exp_t;
  exp_t expq [$];

  always #10 clk = ~clk;

  xlt_unit u_xlt_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .base_wr(base_wr), .base_data(base_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // memory model: one word back the cycle after each accepted read
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
      reads <= reads + 1;
      rd_log.push_back(mem_req_addr);
    end
  end

  // monitor: compare every transferred response with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R11", "unexpected response", rsp_paddr, 32'h0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rsp_paddr == e.pa, e.req, "paddr", rsp_paddr, e.pa);
        check(rsp_fault == e.flt, e.req, "fault", {30'h0, rsp_fault}, {30'h0, e.flt});
      end
      rsp_cnt <= rsp_cnt + 1;
    end
  end

  task automatic map_page(input logic [31:0] base, input logic [31:0] tbl,
                          input logic [31:0] va, input logic [19:0] frame);
    mem[base + {20'h0, va[31:22], 2'b00}] = {tbl[31:12], 12'h001};
    mem[tbl + {20'h0, va[21:12], 2'b00}]  = {frame, 12'h001};
  endtask

  task automatic pulse(input bit is_flush, input logic [31:0] val);
    @(negedge clk);
    if (is_flush) flush = 1'b1; else begin base_wr = 1'b1; base_data = val; end
    @(negedge clk);
    flush = 1'b0; base_wr = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit user, input logic [31:0] pa,
                       input logic [1:0] flt, input int nrd, input logic [31:0] dir_a,
                       input logic [31:0] tbl_a, input bit exp_hit, input string req);
    int r0, n0;
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.pa = pa; e.flt = flt; e.req = req;
    expq.push_back(e);
    r0 = reads; n0 = rsp_cnt;
    rd_log.delete();
    req_valid = 1'b1; req_vaddr = va; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11", "ready low after accept", {31'h0, req_ready}, 32'h0);
    if (exp_hit) check(rsp_valid, "R7", "hit latency", {31'h0, rsp_valid}, 32'h1);
    while (rsp_cnt == n0) @(negedge clk);
    @(negedge clk);
    check(reads - r0 == nrd, req, "read count", 32'(reads - r0), 32'(nrd));
    if (nrd >= 1 && rd_log.size() >= 1) check(rd_log[0] == dir_a, "R1", "dir addr", rd_log[0], dir_a);
    if (nrd >= 2 && rd_log.size() >= 2) check(rd_log[1] == tbl_a, "R2", "tbl addr", rd_log[1], tbl_a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] B, B2;
    B = 32'h0001_0000; B2 = 32'h0005_0000;
    map_page(B, 32'h0002_0000, 32'h0040_3000, 20'h12345);
    mem[B + 32'h4] = {20'h00020, 12'h001};           // dir 1 present, idx 5 absent
    map_page(B, 32'h0002_8000, 32'hC000_1000, 20'hABCDE);
    map_page(B, 32'h0002_C000, 32'hBFFF_F000, 20'h0BEEF);
    for (int i = 0; i < 9; i++)
      map_page(B, 32'h0002_4000, 32'h0080_0000 + 32'(i) * 32'h1000, 20'h30000 + 20'(i));
    map_page(B2, 32'h0006_0000, 32'h0040_3000, 20'h55555);

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R12", "reset ready", {31'h0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R12", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check(mem_req_valid == 1'b0, "R12", "reset mem_req", {31'h0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    pulse(1'b0, B);

    // R1 R2 R3 full walk, then a hit on the same page
    xlate(32'h0040_3123, 0, 32'h1234_5123, 2'b00, 2, B + 32'h4, 32'h0002_000C, 0, "R3");
    xlate(32'h0040_3FFC, 0, 32'h1234_5FFC, 2'b00, 0, 0, 0, 1, "R7");
    // R4 absent directory entry
    xlate(32'h0800_0000, 0, 32'h0, 2'b01, 1, B + 32'h80, 0, 0, "R4");
    // R5 absent table entry, twice
    xlate(32'h0040_5000, 0, 32'h0, 2'b01, 2, B + 32'h4, 32'h0002_0014, 0, "R5");
    xlate(32'h0040_5000, 0, 32'h0, 2'b01, 2, B + 32'h4, 32'h0002_0014, 0, "R5");
    // R6 privilege boundary
    xlate(32'hC000_1000, 1, 32'h0, 2'b10, 0, 0, 0, 0, "R6");
    xlate(32'hC000_1010, 0, 32'hABCD_E010, 2'b00, 2, B + 32'hC00, 32'h0002_8004, 0, "R6");
    xlate(32'hC000_1020, 1, 32'h0, 2'b10, 0, 0, 0, 0, "R6");
    xlate(32'hBFFF_F010, 1, 32'h0BEE_F010, 2'b00, 2, B + 32'hBFC, 32'h0002_CFFC, 0, "R6");
    xlate(32'hBFFF_F020, 0, 32'h0BEE_F020, 2'b00, 0, 0, 0, 1, "R7");
    // R9 flush
    pulse(1'b1, 0);
    xlate(32'h0040_3123, 0, 32'h1234_5123, 2'b00, 2, B + 32'h4, 32'h0002_000C, 0, "R9");
    pulse(1'b1, 0);
    // R8 round robin
    for (int i = 0; i < 8; i++)
      xlate(32'h0080_0000 + 32'(i) * 32'h1000, 0, {20'h30000 + 20'(i), 12'h0}, 2'b00, 2,
            B + 32'h8, 32'h0002_4000 + 32'(i) * 4, 0, "R8");
    for (int i = 0; i < 8; i++)
      xlate(32'h0080_0000 + 32'(i) * 32'h1000, 0, {20'h30000 + 20'(i), 12'h0}, 2'b00, 0,
            0, 0, 1, "R8");
    xlate(32'h0080_8000, 0, 32'h3000_8000, 2'b00, 2, B + 32'h8, 32'h0002_4020, 0, "R8");
    xlate(32'h0080_1000, 0, 32'h3000_1000, 2'b00, 0, 0, 0, 1, "R8");
    xlate(32'h0080_0000, 0, 32'h3000_0000, 2'b00, 2, B + 32'h8, 32'h0002_4000, 0, "R8");
    xlate(32'h0080_2000, 0, 32'h3000_2000, 2'b00, 0, 0, 0, 1, "R8");
    // R10 new base empties the cache
    pulse(1'b0, B2);
    xlate(32'h0040_3ABC, 0, 32'h5555_5ABC, 2'b00, 2, B2 + 32'h4, 32'h0006_000C, 0, "R10");
    xlate(32'h0080_2000, 0, 32'h0, 2'b01, 1, B2 + 32'h8, 0, 0, "R10");

    // R11 back-pressure on a hit
    begin
      exp_t e;
      int n0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      rsp_ready = 1'b0;
      e.pa = 32'h5555_5004; e.flt = 2'b00; e.req = "R11";
      expq.push_back(e);
      n0 = rsp_cnt;
      req_valid = 1'b1; req_vaddr = 32'h0040_3004; req_user = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
        check(rsp_valid, "R11", "held valid", {31'h0, rsp_valid}, 32'h1);
        check(rsp_paddr == 32'h5555_5004, "R11", "held paddr", rsp_paddr, 32'h5555_5004);
        check(!req_ready, "R11", "ready low while held", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
      end
      rsp_ready = 1'b1;
      while (rsp_cnt == n0) @(negedge clk);
      @(negedge clk);
      check(req_ready, "R11", "ready after take", {31'h0, req_ready}, 32'h1);
    end

    check(expq.size() == 0, "R11", "scoreboard drained", 32'(expq.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule